// File: doc/BRIEF.md
# Power-Up Strap Capture and Sticky Output-Enable Controller

This block sits between a multi-output clock source and its pads. When power-on reset releases, it reads a 5-bit configuration word from pads that are later reused as clock outputs. It keeps that word until the next power-on reset. The word is decoded into a table index and a flag that selects the phase-aligned multiplier mode. Once the word is held, a timed turnaround hands the shared pads over to clock duty.

The block also owns the output-enable for every clock pad. The enable pin is synchronised, and the first low level it shows disables all outputs. Raising the pin again does not bring them back. Only another power-on reset re-arms the outputs. After reset the synchronisers hold a high value, so an open enable pin reads as "enabled" and an open select pad reads as 1.

Top module: `strap_oe_ctrl`

## Requirements
- R1: While `por_n` is low, `pad_oe`, `pad_out`, `cfg_addr`, `zd_mode` and `ready` are all 0.
- R2: `cfg_addr[i]` takes the level of `pad_in[i]`. The value is visible after the third rising edge following `por_n` release, and `cfg_addr` is 0 before that edge.
- R3: Once captured, `cfg_addr` ignores any later change of `pad_in` until the next power-on reset.
- R4: The shared pads are output indices SEL_BASE to SEL_BASE+NSEL-1, which is 27 to 31 by default. Their `pad_oe` bits stay 0 until `ready` rises. `ready` rises at rising edge 3+TURN_TICKS after reset release and then stays high.
- R5: The dedicated (non-shared) outputs have `pad_oe` set from the capture edge onward, unless they are disabled.
- R6: `zd_mode` is 1 exactly when the captured address is 24 or above (multiplier mode). It is 0 for addresses 0 to 23 (generator mode) and 0 before capture.
- R7: Suppose `oe_pad` goes low and is sampled at rising edge A. All `pad_oe` bits are 0 after edge A+2. They remain 0 when `oe_pad` returns high, until the next power-on reset.
- R8: A low `oe_pad` held only during reset has no effect. With `oe_pad` high after release, the outputs enable normally.
- R9: `pad_out[i]` equals `clk_src[i]` when `pad_oe[i]` is 1, and is 0 otherwise.
- R10: A new power-on reset samples `pad_in` again, so a different strap value replaces the previously held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| oe_pad | input | 1 | Output-enable pin level (pulled high) |
| pad_in | input | NSEL | Input levels of the shared select pads |
| clk_src | input | NOUT | Per-output clock sources |
| pad_out | output | NOUT | Pad drive values |
| pad_oe | output | NOUT | Pad output enables |
| cfg_addr | output | NSEL | Latched configuration address |
| zd_mode | output | 1 | Multiplier (zero-delay) mode flag |
| ready | output | 1 | Address latched and shared pads turned to outputs |

## Verification
The assertions check several properties on every cycle:
- the shared-pad enables stay low until `ready`;
- the address is frozen and `ready` is held once it rises;
- the mode flag agrees with the held address;
- a floated output set never re-enables;
- a disabled pad never drives a clock value.

Only the bench's scenarios can show the rest:
- the exact capture cycle and the exact turnaround cycle;
- that later pad activity is ignored;
- the three-edge disable latency;
- that a low enable pin seen only during reset is harmless;
- re-sampling across successive power cycles with random strap values.

// File: rtl/strap_oe_ctrl.sv
module strap_oe_ctrl #(
  parameter int NOUT       = 32,
  parameter int NSEL       = 5,
  parameter int SEL_BASE   = 27,
  parameter int ZD_FIRST   = 24,
  parameter int TURN_TICKS = 1000000
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            oe_pad,
  input  logic [NSEL-1:0] pad_in,
  input  logic [NOUT-1:0] clk_src,
  output logic [NOUT-1:0] pad_out,
  output logic [NOUT-1:0] pad_oe,
  output logic [NSEL-1:0] cfg_addr,
  output logic            zd_mode,
  output logic            ready
);

  localparam int CW = $clog2(TURN_TICKS + 1);
  localparam logic [CW-1:0]   CNT_LAST = CW'(TURN_TICKS - 1);
  localparam logic [NSEL-1:0] ZD_CODE  = NSEL'(ZD_FIRST);

  logic [NSEL-1:0] sel_s1, sel_s2;
  logic [1:0]      fill;
  logic            latched;
  logic [CW-1:0]   cnt;
  logic            turned;
  logic            oe_s1, oe_s2;
  logic            dis;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sel_s1   <= '1;
      sel_s2   <= '1;
      fill     <= 2'd0;
      latched  <= 1'b0;
      cfg_addr <= '0;
    end else begin
      sel_s1 <= pad_in;
      sel_s2 <= sel_s1;
      if (!latched) begin
        if (fill == 2'd2) begin
          cfg_addr <= sel_s2;
          latched  <= 1'b1;
        end else begin
          fill <= fill + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt    <= '0;
      turned <= 1'b0;
    end else if (latched && !turned) begin
      if (cnt == CNT_LAST) turned <= 1'b1;
      else                 cnt    <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      oe_s1 <= 1'b1;
      oe_s2 <= 1'b1;
      dis   <= 1'b0;
    end else begin
      oe_s1 <= oe_pad;
      oe_s2 <= oe_s1;
      dis   <= dis | ~oe_s2;
    end
  end

  assign ready   = turned;
  assign zd_mode = latched & (cfg_addr >= ZD_CODE);

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    if (g >= SEL_BASE && g < SEL_BASE + NSEL) begin : g_shared
      assign pad_oe[g] = turned & ~dis;
    end else begin : g_dedic
      assign pad_oe[g] = latched & ~dis;
    end
    assign pad_out[g] = clk_src[g] & pad_oe[g];
  end

endmodule

// File: rtl/strap_oe_chk.sv
module strap_oe_chk #(
  parameter int NOUT     = 32,
  parameter int NSEL     = 5,
  parameter int SEL_BASE = 27,
  parameter int ZD_FIRST = 24
) (
  input logic            clk,
  input logic            por_n,
  input logic [NOUT-1:0] pad_out,
  input logic [NOUT-1:0] pad_oe,
  input logic [NSEL-1:0] cfg_addr,
  input logic            zd_mode,
  input logic            ready
);
  localparam logic [NOUT-1:0] SHM = NOUT'(((64'd1 << NSEL) - 64'd1) << SEL_BASE);
  localparam logic [NSEL-1:0] ZD_CODE = NSEL'(ZD_FIRST);

  always @(posedge clk) begin
    if (!por_n) AST_RESET_FLOAT: assert (pad_oe == '0 && !ready); // R1
  end

  AST_SHARED_HELD: assert property (@(posedge clk) disable iff (!por_n)
    !ready |-> ((pad_oe & SHM) == '0)); // R4
  AST_READY_KEEPS: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready); // R4
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> $stable(cfg_addr)); // R3
  AST_MODE_MATCH: assert property (@(posedge clk) disable iff (!por_n)
    ready |-> (zd_mode == (cfg_addr >= ZD_CODE))); // R6
  AST_FLOAT_STAYS: assert property (@(posedge clk) disable iff (!por_n)
    (ready && pad_oe == '0) |=> (pad_oe == '0)); // R7
  AST_QUIET_DRIVE: assert property (@(posedge clk) disable iff (!por_n)
    (pad_out & ~pad_oe) == '0); // R9
endmodule

bind strap_oe_ctrl strap_oe_chk #(
  .NOUT(NOUT), .NSEL(NSEL), .SEL_BASE(SEL_BASE), .ZD_FIRST(ZD_FIRST)
) u_chk (
  .clk(clk), .por_n(por_n), .pad_out(pad_out), .pad_oe(pad_oe),
  .cfg_addr(cfg_addr), .zd_mode(zd_mode), .ready(ready)
);

// File: tb/sim_strap_oe_ctrl.sv
`timescale 1ns/1ps
module sim_strap_oe_ctrl;
  localparam int NOUT = 32, NSEL = 5, SEL_BASE = 27, ZD_FIRST = 24, T = 12;
  localparam logic [NOUT-1:0] SHM = 32'hF800_0000;

  logic clk = 1'b0, por_n = 1'b0, oe_pad = 1'b1;
  logic [NSEL-1:0] pad_in = '1;
  logic [NOUT-1:0] clk_src = '0;
  logic [NOUT-1:0] pad_out, pad_oe;
  logic [NSEL-1:0] cfg_addr;
  logic zd_mode, ready;
  int total = 0, bad = 0;
  logic [NSEL-1:0] prev_addr = '0;

  always #5 clk = ~clk;

  strap_oe_ctrl #(.NOUT(NOUT), .NSEL(NSEL), .SEL_BASE(SEL_BASE),
                  .ZD_FIRST(ZD_FIRST), .TURN_TICKS(T)) u0 (
    .clk(clk), .por_n(por_n), .oe_pad(oe_pad), .pad_in(pad_in), .clk_src(clk_src),
    .pad_out(pad_out), .pad_oe(pad_oe), .cfg_addr(cfg_addr), .zd_mode(zd_mode), .ready(ready));

  function automatic logic exp_zd(input logic [NSEL-1:0] a);
    return a >= NSEL'(ZD_FIRST);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic power_cycle(input logic [NSEL-1:0] addr, input bit do_dis, input bit oe_low_in_rst);
    logic [NOUT-1:0] on;
    @(negedge clk);
    por_n = 1'b0; pad_in = addr; oe_pad = !oe_low_in_rst; clk_src = $urandom;
    repeat (3) @(negedge clk);
    chk(pad_oe == '0 && pad_out == '0 && !ready && cfg_addr == '0 && !zd_mode, "R1",
        {pad_oe, 27'd0, cfg_addr}, 64'd0);
    por_n = 1'b1; oe_pad = 1'b1;
    step(2);
    chk(cfg_addr == '0 && pad_oe == '0, "R2 early", {pad_oe, 27'd0, cfg_addr}, 64'd0);
    step(1);
    chk(cfg_addr == addr, "R2", cfg_addr, addr);
    if (prev_addr != addr) chk(cfg_addr == addr, "R10", cfg_addr, addr);
    prev_addr = addr;
    chk(zd_mode == exp_zd(addr), "R6", zd_mode, exp_zd(addr));
    on = ~SHM;
    chk(pad_oe == on, oe_low_in_rst ? "R8" : "R5", pad_oe, on);
    chk(pad_out == (clk_src & on), "R9", pad_out, clk_src & on);
    @(negedge clk);
    pad_in = ~addr ^ NSEL'($urandom);
    step(T - 1);
    chk(!ready && (pad_oe & SHM) == '0, "R4 early", {ready, pad_oe}, {1'b0, on});
    step(1);
    chk(ready && pad_oe == '1, "R4", {ready, pad_oe}, {1'b1, 32'hFFFF_FFFF});
    chk(cfg_addr == addr, "R3", cfg_addr, addr);
    chk(zd_mode == exp_zd(addr), "R6 held", zd_mode, exp_zd(addr));
    if (do_dis) begin
      @(negedge clk); oe_pad = 1'b0;
      step(2);
      chk(pad_oe == '1, "R7 latency", pad_oe, 32'hFFFF_FFFF);
      step(1);
      chk(pad_oe == '0, "R7", pad_oe, 0);
      @(negedge clk); oe_pad = 1'b1; clk_src = $urandom | 32'h1;
      step(6);
      chk(pad_oe == '0 && pad_out == '0, "R7 sticky", {pad_oe, pad_out}, 0);
      chk(ready && cfg_addr == addr, "R3 after dis", cfg_addr, addr);
    end else begin
      for (int k = 0; k < 4; k++) begin
        @(negedge clk); clk_src = $urandom;
        step(1);
        chk(pad_out == clk_src && pad_oe == '1, "R9 run", pad_out, clk_src);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    #1;
    power_cycle(5'd23, 1'b0, 1'b0);
    power_cycle(5'd24, 1'b1, 1'b0);
    power_cycle(5'd0,  1'b0, 1'b1);
    power_cycle(5'd31, 1'b1, 1'b1);
    for (int i = 0; i < 16; i++)
      power_cycle(NSEL'($urandom), 1'($urandom), 1'($urandom));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule